// File: doc/BRIEF.md
# DMA Request Arbiter

This block decides which of several DMA channels is served next. Each channel's request pin is sampled through one register. The pin's active level is chosen at run time. Per-channel mask bits and a global disable bit then filter the sampled requests. A fixed or a rotating priority scheme picks one channel from what remains. The arbiter then raises a bus hold request. Once the hold acknowledge comes back, it drives a one-hot acknowledge vector whose active level is also programmable. The grant stays on that channel until the transfer logic reports that the service is over.

The block also holds the 8-bit command word. Besides the arbitration controls, that word carries four option bits that other parts of the controller read: memory-to-memory, channel-0 address hold, compressed timing and extended write. Host writes to the command word and to the mask bits are refused while the hold acknowledge is high and on the first clock edge after it falls. A master-clear strobe returns the block to its reset state.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset the command word is 0x00, all mask bits are 1, `hrq` is low, every `dack_pin` is inactive (all ones, since bit 7 is 0), and `prog_ok` is high while `hlda` is low.
- R2: A master-clear strobe accepted while `prog_ok` is high sets the command word to 0x00 and all mask bits to 1. It also drops any pending or active grant and restarts the rotation at channel 0.
- R3: While command bit 2 is 1, no new grant starts and `hrq` stays low. Clearing the bit lets pending unmasked requests be served.
- R4: Mask bit i (1 = masked) blocks channel i. A request on a masked channel never raises `hrq` or its acknowledge.
- R5: With command bit 4 at 0, the lowest-numbered eligible channel wins: channel 0 is highest and the last channel is lowest.
- R6: With command bit 4 at 1, the channel that finished last becomes the lowest priority, and the search starts at the channel numbered one above it (wrapping).
- R7: With command bit 6 at 0 a request pin is active high, and with it at 1 the pin is active low. Pins are sampled on one edge, and arbitration uses that sample on the following edge.
- R8: With command bit 7 at 0 the acknowledges are active low, and with it at 1 they are active high. At most one is active, and only from the edge that sees `hlda` high with a grant pending until the edge that sees `xfer_done`.
- R9: `hrq` rises on the edge after an eligible sample and then stays high, without preemption, until `xfer_done` is seen during service. It then falls for at least one cycle.
- R10: `prog_ok` is low while `hlda` is high and until one rising edge has passed with `hlda` low. Command, mask and master-clear strobes are ignored while it is low.
- R11: Command bits 0, 1, 3 and 5 appear unchanged on `mem2mem_en`, `ch0_addr_hold`, `compressed_timing` and `extended_write`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mclr | input | 1 | Master-clear strobe |
| host_wr_cmd | input | 1 | Command word write strobe |
| host_cmd_data | input | CMD_W | Command word write data |
| host_wr_mask | input | 1 | Mask write strobe |
| host_mask_data | input | NUM_CH | Mask write data, bit i for channel i |
| dreq_pin | input | NUM_CH | Channel request pins |
| hlda | input | 1 | Bus hold acknowledge |
| xfer_done | input | 1 | End of service for the granted channel |
| hrq | output | 1 | Bus hold request |
| dack_pin | output | NUM_CH | Channel acknowledge pins |
| prog_ok | output | 1 | Host access window open |
| cmd_q | output | CMD_W | Current command word |
| mask_q | output | NUM_CH | Current mask bits |
| mem2mem_en | output | 1 | Memory-to-memory option |
| ch0_addr_hold | output | 1 | Channel-0 address hold option |
| compressed_timing | output | 1 | Compressed timing option |
| extended_write | output | 1 | Extended write option |

## Verification
The hardest state to reach is a rotation pointer sitting on a channel the stimulus chose, with a partial request set pending. Only completed services move the pointer. The bench therefore runs a full sweep with every request held and then a sparse pattern, so the wrap-around choice can be seen. The bench also has to reach a competing request that arrives during a held service, as well as the single-edge lockout after hold acknowledge falls. To do this, the service task changes the request pins mid-service and at the completion edge, and the bench attempts writes on the first edge after release.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   // Command word bit positions; the host encodes these values.
   localparam int CB_MEM2MEM   = 0;
   localparam int CB_CH0_HOLD  = 1;
   localparam int CB_DISABLE   = 2;
   localparam int CB_COMPRESS  = 3;
   localparam int CB_ROTATE    = 4;
   localparam int CB_EXTWRITE  = 5;
   localparam int CB_DREQ_LOW  = 6;
   localparam int CB_DACK_HIGH = 7;

   typedef enum logic [1:0] {
      ARB_IDLE  = 2'd0,
      ARB_WAIT  = 2'd1,
      ARB_SERVE = 2'd2
   } arb_state_e;

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active_low,
   input  logic [NUM_CH-1:0] dreq_pin,
   output logic [NUM_CH-1:0] req_q
);

   if (NUM_CH < 1) begin : g_bad_width
      $error("dma_req_sync: NUM_CH must be at least 1");
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic level;
      assign level = active_low ? ~dreq_pin[i] : dreq_pin[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) req_q[i] <= 1'b0;
         else        req_q[i] <= level;
      end
   end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
   parameter int NUM_CH         = 4,
   parameter bit ROTATE_SUPPORT = 1'b1,
   localparam int IDX_W         = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] req,
   input  logic              rotate,
   input  logic [IDX_W-1:0]  top,
   output logic              found,
   output logic [IDX_W-1:0]  pick
);

   localparam logic [IDX_W:0] CH_LIMIT = (IDX_W+1)'(NUM_CH);

   if (NUM_CH < 2) begin : g_bad_count
      $error("dma_prio_pick: NUM_CH must be at least 2");
   end

   logic [IDX_W-1:0] base;
   logic [IDX_W-1:0] idx_a [NUM_CH];
   logic [NUM_CH-1:0] hit;

   if (ROTATE_SUPPORT) begin : g_rot
      assign base = rotate ? top : '0;
   end else begin : g_fixed_only
      logic unused_rot;
      assign unused_rot = rotate ^ (^top);
      assign base = '0;
   end

   // Slot o holds the channel searched o-th, starting at base.
   for (genvar o = 0; o < NUM_CH; o++) begin : g_slot
      logic [IDX_W:0] sum;
      logic [IDX_W:0] wrapped;
      assign sum     = {1'b0, base} + (IDX_W+1)'(o);
      assign wrapped = (sum >= CH_LIMIT) ? (sum - CH_LIMIT) : sum;
      assign idx_a[o] = wrapped[IDX_W-1:0];
      assign hit[o]   = req[idx_a[o]];
   end

   always_comb begin
      found = |hit;
      pick  = '0;
      for (int o = NUM_CH - 1; o >= 0; o--) begin
         if (hit[o]) pick = idx_a[o];
      end
   end

endmodule

// File: rtl/dma_cmd_regs.sv
module dma_cmd_regs #(
   parameter int NUM_CH = 4,
   parameter int CMD_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hlda,
   input  logic              host_mclr,
   input  logic              host_wr_cmd,
   input  logic [CMD_W-1:0]  host_cmd_data,
   input  logic              host_wr_mask,
   input  logic [NUM_CH-1:0] host_mask_data,
   output logic [CMD_W-1:0]  cmd_q,
   output logic [NUM_CH-1:0] mask_q,
   output logic              prog_ok,
   output logic              mclr_ok
);

   if (CMD_W != 8) begin : g_bad_cmd
      $error("dma_cmd_regs: command word must be 8 bits");
   end

   logic hlda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hlda_q <= 1'b0;
      else        hlda_q <= hlda;
   end

   // Open only when hold is low now and was low at the previous edge.
   assign prog_ok = ~hlda & ~hlda_q;
   assign mclr_ok = host_mclr & prog_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (mclr_ok) begin
         cmd_q <= '0;
      end else if (host_wr_cmd && prog_ok) begin
         cmd_q <= host_cmd_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (mclr_ok) begin
         mask_q <= '1;
      end else if (host_wr_mask && prog_ok) begin
         mask_q <= host_mask_data;
      end
   end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH         = 4,
   parameter int CMD_W          = 8,
   parameter bit ROTATE_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_mclr,
   input  logic              host_wr_cmd,
   input  logic [CMD_W-1:0]  host_cmd_data,
   input  logic              host_wr_mask,
   input  logic [NUM_CH-1:0] host_mask_data,
   input  logic [NUM_CH-1:0] dreq_pin,
   input  logic              hlda,
   input  logic              xfer_done,
   output logic              hrq,
   output logic [NUM_CH-1:0] dack_pin,
   output logic              prog_ok,
   output logic [CMD_W-1:0]  cmd_q,
   output logic [NUM_CH-1:0] mask_q,
   output logic              mem2mem_en,
   output logic              ch0_addr_hold,
   output logic              compressed_timing,
   output logic              extended_write
);

   localparam int IDX_W = $clog2(NUM_CH);
   localparam logic [IDX_W-1:0] LAST_CH = IDX_W'(NUM_CH - 1);

   if (NUM_CH < 2) begin : g_bad_ch
      $error("dma_req_arbiter: NUM_CH must be at least 2");
   end

   logic              mclr_ok;
   logic [NUM_CH-1:0] req_q;
   logic [NUM_CH-1:0] eligible;
   logic              found;
   logic [IDX_W-1:0]  pick;
   logic              start;
   arb_state_e        state_q;
   logic [IDX_W-1:0]  chan_q;
   logic [IDX_W-1:0]  top_q;
   logic [IDX_W-1:0]  next_top;
   logic [NUM_CH-1:0] grant;

   dma_cmd_regs #(
      .NUM_CH (NUM_CH),
      .CMD_W  (CMD_W)
   ) u_regs (
      .clk            (clk),
      .rst_n          (rst_n),
      .hlda           (hlda),
      .host_mclr      (host_mclr),
      .host_wr_cmd    (host_wr_cmd),
      .host_cmd_data  (host_cmd_data),
      .host_wr_mask   (host_wr_mask),
      .host_mask_data (host_mask_data),
      .cmd_q          (cmd_q),
      .mask_q         (mask_q),
      .prog_ok        (prog_ok),
      .mclr_ok        (mclr_ok)
   );

   dma_req_sync #(
      .NUM_CH (NUM_CH)
   ) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .active_low (cmd_q[CB_DREQ_LOW]),
      .dreq_pin   (dreq_pin),
      .req_q      (req_q)
   );

   assign eligible = req_q & ~mask_q;

   dma_prio_pick #(
      .NUM_CH         (NUM_CH),
      .ROTATE_SUPPORT (ROTATE_SUPPORT)
   ) u_pick (
      .req    (eligible),
      .rotate (cmd_q[CB_ROTATE]),
      .top    (top_q),
      .found  (found),
      .pick   (pick)
   );

   assign start    = found & ~cmd_q[CB_DISABLE];
   assign next_top = (chan_q == LAST_CH) ? '0 : chan_q + IDX_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ARB_IDLE;
         chan_q  <= '0;
         top_q   <= '0;
      end else if (mclr_ok) begin
         state_q <= ARB_IDLE;
         chan_q  <= '0;
         top_q   <= '0;
      end else begin
         unique case (state_q)
            ARB_IDLE: begin
               if (start) begin
                  state_q <= ARB_WAIT;
                  chan_q  <= pick;
               end
            end
            ARB_WAIT: begin
               if (hlda) state_q <= ARB_SERVE;
            end
            ARB_SERVE: begin
               if (xfer_done) begin
                  state_q <= ARB_IDLE;
                  top_q   <= next_top;
               end
            end
            default: state_q <= ARB_IDLE;
         endcase
      end
   end

   assign hrq = (state_q != ARB_IDLE);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_dack
      assign grant[i]    = (state_q == ARB_SERVE) && (chan_q == IDX_W'(i));
      assign dack_pin[i] = cmd_q[CB_DACK_HIGH] ? grant[i] : ~grant[i];
   end

   assign mem2mem_en        = cmd_q[CB_MEM2MEM];
   assign ch0_addr_hold     = cmd_q[CB_CH0_HOLD];
   assign compressed_timing = cmd_q[CB_COMPRESS];
   assign extended_write    = cmd_q[CB_EXTWRITE];

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
   parameter int NUM_CH = 4,
   parameter int CMD_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hlda,
   input logic              xfer_done,
   input logic              hrq,
   input logic              prog_ok,
   input logic              mclr_ok,
   input logic [NUM_CH-1:0] dack_pin,
   input logic [CMD_W-1:0]  cmd_q
);

   logic [NUM_CH-1:0] dack_act;
   assign dack_act = cmd_q[7] ? dack_pin : ~dack_pin;

   a_r8_dack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dack_act));

   a_r8_dack_needs_hrq: assert property (@(posedge clk) disable iff (!rst_n)
      (|dack_act) |-> hrq);

   a_r9_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (hrq && !xfer_done && !mclr_ok) |=> hrq);

   a_r3_disabled_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!hrq && cmd_q[2]) |=> !hrq);

   a_r10_closed_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
      hlda |-> !prog_ok);

   a_r10_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (hlda || $past(hlda)) |=> $stable(cmd_q));

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(
   .NUM_CH (NUM_CH),
   .CMD_W  (CMD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hlda      (hlda),
   .xfer_done (xfer_done),
   .hrq       (hrq),
   .prog_ok   (prog_ok),
   .mclr_ok   (mclr_ok),
   .dack_pin  (dack_pin),
   .cmd_q     (cmd_q)
);

// File: tb/dma_req_arbiter_test.sv
module dma_req_arbiter_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_mclr = 1'b0;
   logic       host_wr_cmd = 1'b0;
   logic [7:0] host_cmd_data = '0;
   logic       host_wr_mask = 1'b0;
   logic [3:0] host_mask_data = '0;
   logic [3:0] dreq_pin = '0;
   logic       hlda = 1'b0;
   logic       xfer_done = 1'b0;
   logic       hrq;
   logic [3:0] dack_pin;
   logic       prog_ok;
   logic [7:0] cmd_q;
   logic [3:0] mask_q;
   logic       mem2mem_en, ch0_addr_hold, compressed_timing, extended_write;

   always #4 clk = ~clk;

   dma_req_arbiter uut (
      .clk(clk), .rst_n(rst_n), .host_mclr(host_mclr),
      .host_wr_cmd(host_wr_cmd), .host_cmd_data(host_cmd_data),
      .host_wr_mask(host_wr_mask), .host_mask_data(host_mask_data),
      .dreq_pin(dreq_pin), .hlda(hlda), .xfer_done(xfer_done),
      .hrq(hrq), .dack_pin(dack_pin), .prog_ok(prog_ok),
      .cmd_q(cmd_q), .mask_q(mask_q), .mem2mem_en(mem2mem_en),
      .ch0_addr_hold(ch0_addr_hold), .compressed_timing(compressed_timing),
      .extended_write(extended_write)
   );

   int  checks = 0;
   int  fails  = 0;
   bit  finished = 1'b0;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // Behavioural reference model, advanced on every rising edge.
   int         m_state = 0;
   int         m_ch = 0;
   int         m_top = 0;
   logic [7:0] m_cmd = '0;
   logic [3:0] m_mask = 4'hF;
   logic [3:0] m_req = '0;
   logic       m_hq = 1'b0;
   bit         m_live = 1'b0;

   always @(posedge clk) begin
      bit         acc;
      logic [3:0] nreq;
      logic [3:0] eff;
      int         pk;
      m_live = 1'b1;
      if (!rst_n) begin
         m_state = 0; m_ch = 0; m_top = 0; m_cmd = '0; m_mask = 4'hF;
         m_req = '0; m_hq = 1'b0;
      end else begin
         acc  = !hlda && !m_hq;
         nreq = m_cmd[6] ? ~dreq_pin : dreq_pin;
         eff  = m_req & ~m_mask;
         if (acc && host_mclr) begin
            m_cmd = '0; m_mask = 4'hF; m_state = 0; m_ch = 0; m_top = 0;
         end else begin
            case (m_state)
               0: if (!m_cmd[2] && eff != 0) begin
                     pk = -1;
                     for (int k = 0; k < 4; k++) begin
                        int c;
                        c = m_cmd[4] ? (m_top + k) % 4 : k;
                        if (pk < 0 && eff[c]) pk = c;
                     end
                     m_ch = pk;
                     m_state = 1;
                  end
               1: if (hlda) m_state = 2;
               default: if (xfer_done) begin
                     m_state = 0;
                     m_top = (m_ch + 1) % 4;
                  end
            endcase
            if (acc && host_wr_cmd)  m_cmd  = host_cmd_data;
            if (acc && host_wr_mask) m_mask = host_mask_data;
         end
         m_hq  = hlda;
         m_req = nreq;
      end
   end

   always @(negedge clk) begin
      logic [3:0] ed;
      if (m_live && rst_n && !finished) begin
         ed = '0;
         if (m_state == 2) ed[m_ch] = 1'b1;
         if (!m_cmd[7]) ed = ~ed;
         chk(hrq === (m_state != 0), "R9 hrq vs model", hrq, m_state != 0);
         chk(dack_pin === ed, "R8 dack vs model", dack_pin, ed);
         chk(prog_ok === (!hlda && !m_hq), "R10 prog_ok vs model", prog_ok, !hlda && !m_hq);
         chk(cmd_q === m_cmd, "R11 cmd vs model", cmd_q, m_cmd);
         chk(mask_q === m_mask, "R4 mask vs model", mask_q, m_mask);
         chk({extended_write, compressed_timing, ch0_addr_hold, mem2mem_en} ===
             {m_cmd[5], m_cmd[3], m_cmd[1], m_cmd[0]}, "R11 option bits vs model",
             {extended_write, compressed_timing, ch0_addr_hold, mem2mem_en},
             {m_cmd[5], m_cmd[3], m_cmd[1], m_cmd[0]});
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic write_cmd(input logic [7:0] v);
      host_wr_cmd = 1'b1; host_cmd_data = v;
      step();
      host_wr_cmd = 1'b0;
   endtask

   task automatic write_mask(input logic [3:0] v);
      host_wr_mask = 1'b1; host_mask_data = v;
      step();
      host_wr_mask = 1'b0;
   endtask

   task automatic expect_idle(input int n, input string rq);
      repeat (n) step();
      chk(hrq === 1'b0, rq, hrq, 0);
   endtask

   // Wait for hrq, grant, check the acknowledge for hold+1 cycles, finish.
   task automatic serve(input int ch, input bit hi, input int hold,
                        input logic [3:0] mid, input logic [3:0] nxt, input string rq);
      int w = 0;
      while (hrq !== 1'b1 && w < 20) begin step(); w++; end
      chk(hrq === 1'b1, rq, hrq, 1);
      hlda = 1'b1;
      step();
      dreq_pin = mid;
      for (int h = 0; h <= hold; h++) begin
         logic [3:0] e;
         e = hi ? 4'(1 << ch) : ~4'(1 << ch);
         chk(dack_pin === e, rq, dack_pin, e);
         chk(hrq === 1'b1, rq, hrq, 1);
         if (h < hold) step();
      end
      xfer_done = 1'b1; dreq_pin = nxt;
      step();
      xfer_done = 1'b0; hlda = 1'b0;
      chk(hrq === 1'b0, rq, hrq, 0);
      step();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      chk(hrq === 1'b0 && dack_pin === 4'hF && prog_ok === 1'b1, "R1 outputs after reset",
          {hrq, dack_pin, prog_ok}, {1'b0, 4'hF, 1'b1});
      chk(cmd_q === 8'h00 && mask_q === 4'hF, "R1 registers after reset",
          {cmd_q, mask_q}, {8'h00, 4'hF});
      expect_idle(3, "R4 all masked after reset");

      // Fixed priority
      write_mask(4'h0);
      write_cmd(8'h00);
      dreq_pin = 4'b1010;
      serve(1, 0, 0, 4'b1010, 4'b1010, "R5 ch1 over ch3");
      serve(1, 0, 0, 4'b1100, 4'b1100, "R5 ch1 again while held");
      serve(2, 0, 0, 4'b1100, 4'b1000, "R5 ch2 over ch3");
      serve(3, 0, 4, 4'b1001, 4'b0000, "R9 no preemption by ch0");

      // Masking
      write_mask(4'b0010);
      dreq_pin = 4'b0010;
      expect_idle(6, "R4 masked ch1 ignored");
      dreq_pin = 4'b1010;
      serve(3, 0, 0, 4'b1010, 4'b0000, "R4 unmasked ch3 served");

      // Rotating priority, pointer at ch0 after ch3 finished
      write_mask(4'h0);
      write_cmd(8'h10);
      dreq_pin = 4'hF;
      serve(0, 0, 0, 4'hF, 4'hF, "R6 rotate step ch0");
      serve(1, 0, 0, 4'hF, 4'hF, "R6 rotate step ch1");
      serve(2, 0, 0, 4'hF, 4'hF, "R6 rotate step ch2");
      serve(3, 0, 0, 4'hF, 4'hF, "R6 rotate step ch3");
      serve(0, 0, 0, 4'hF, 4'b0101, "R6 rotate wraps to ch0");
      serve(2, 0, 0, 4'b0101, 4'b0101, "R6 search starts after ch0");
      serve(0, 0, 0, 4'b0101, 4'b0000, "R6 wrap past ch3 to ch0");

      // Disable bit
      write_cmd(8'h14);
      dreq_pin = 4'hF;
      expect_idle(6, "R3 disabled controller");
      write_cmd(8'h10);
      serve(1, 0, 0, 4'hF, 4'h0, "R3 service after enable");

      // Request polarity
      write_mask(4'hF);
      dreq_pin = 4'hF;
      write_cmd(8'h40);
      step(); step();
      write_mask(4'h0);
      expect_idle(5, "R7 high pins inactive in low sense");
      dreq_pin = 4'b1011;
      serve(2, 0, 0, 4'b1011, 4'hF, "R7 low pin requests ch2");

      // Acknowledge polarity
      write_cmd(8'hC0);
      chk(dack_pin === 4'h0, "R8 idle acks low in high sense", dack_pin, 4'h0);
      dreq_pin = 4'b0111;
      serve(3, 1, 1, 4'b0111, 4'hF, "R8 active-high ack ch3");

      // Host lockout
      hlda = 1'b1;
      step();
      chk(prog_ok === 1'b0, "R10 closed during hold", prog_ok, 0);
      write_cmd(8'h01);
      chk(cmd_q === 8'hC0, "R10 write ignored in hold", cmd_q, 8'hC0);
      hlda = 1'b0;
      write_cmd(8'h01);
      chk(cmd_q === 8'hC0, "R10 write ignored on first edge after release", cmd_q, 8'hC0);
      write_cmd(8'h01);
      chk(cmd_q === 8'h01, "R10 write accepted after window", cmd_q, 8'h01);

      // Option bits
      write_cmd(8'h2B);
      chk({extended_write, compressed_timing, ch0_addr_hold, mem2mem_en} === 4'hF,
          "R11 option outputs", {extended_write, compressed_timing, ch0_addr_hold, mem2mem_en}, 4'hF);
      write_cmd(8'h08);
      chk({extended_write, compressed_timing, ch0_addr_hold, mem2mem_en} === 4'b0100,
          "R11 compressed only", {extended_write, compressed_timing, ch0_addr_hold, mem2mem_en}, 4'b0100);

      // Master clear with a grant pending
      write_mask(4'h0);
      dreq_pin = 4'b0001;
      step(); step();
      chk(hrq === 1'b1, "R2 grant pending before clear", hrq, 1);
      dreq_pin = 4'h0;
      host_mclr = 1'b1;
      step();
      host_mclr = 1'b0;
      chk(cmd_q === 8'h00 && mask_q === 4'hF && hrq === 1'b0, "R2 master clear",
          {cmd_q, mask_q, hrq}, {8'h00, 4'hF, 1'b0});

      step();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule